// File: doc/BRIEF.md
# Tick-Driven Limit Timer Bank

The block holds a bank of counter/timers behind a word-addressed register port: one system timer and one timer for each CPU. Each unit counts a shared tick enable. When its count reaches a programmed nonzero limit, the unit starts a new period and raises a level interrupt. That interrupt stays asserted until software acknowledges it.

Software acknowledges an interrupt by reading the unit's limit register. A second write address for the limit changes the period without dropping a pending interrupt or restarting the count. A mode register in the system unit can switch any per-CPU unit to a free-running user counter. In that mode the unit is gated by its own run bit and never interrupts.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every limit is 0, every count is 1, every interrupt flag is clear, every per-CPU unit is in timer mode, every run bit is 0, and `irq_sys` and `irq_cpu` are low.
- R2: The address splits into a unit number in `req_addr[ADDR_W-1:2]` and a register offset in `req_addr[1:0]`.
  - Units 0 to NCPU-1 are the per-CPU timers and unit NCPU is the system timer.
  - Offset 0 is the clearing limit, offset 1 is the count, offset 2 is the non-clearing limit, and offset 3 is the run bit (bit 0) of a per-CPU unit or the mode register (bit i for CPU i) of the system unit.
  - Values sit in the low bits and the upper bits read as 0.
  - An unused unit number reads 0.
- R3: In timer mode the count rises by one on each cycle with `tick_en` high. A tick that finds the count equal to a nonzero limit reloads the count to 1 and sets the flag. A period therefore lasts exactly `limit` ticks after a clearing limit write.
- R4: A set flag stays high until the limit is read at offset 0. That read clears it on the next edge. A reading cycle in which a wrapping tick also occurs leaves the flag set.
- R5: A write at offset 0 loads the limit, reloads the count to 1 and clears the flag.
- R6: A write at offset 2 loads the limit and leaves both the count and the flag untouched.
- R7: With a limit of 0 the unit never sets its flag. Its count keeps rising and wraps modulo 2^CNT_W.
- R8: The count register is read-only: writes at offset 1 change nothing. Reads at offsets 1 and 2 have no side effect.
- R9: The system unit's flag drives `irq_sys`, and per-CPU unit i's flag drives `irq_cpu[i]`. Each unit acts independently of the others.
- R10: Mode bit i set to 1 makes CPU unit i a user counter.
  - Its count rises on a tick only while its run bit is 1, ignores the limit and wraps modulo 2^CNT_W.
  - Its flag is held clear.
  - Writing 0 to the mode register returns every unit to timer mode with its count kept.
- R11: A read accepted on one edge presents `rsp_valid` and `rsp_data` after that same edge, for one cycle. `rsp_valid` stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable, one step per high cycle |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Unit number and register offset |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW | Read data |
| irq_sys | output | 1 | System timer interrupt level |
| irq_cpu | output | NCPU | Per-CPU timer interrupt levels |

## Verification
Each result is due at a known edge:
- Every register update, count step, flag set or flag clear is visible one edge after the cycle that caused it.
- Read data comes one edge after the request.

The bench drives all inputs on the falling edge and samples on the next falling edge. Interrupt levels are therefore checked half a cycle after the edge that moves them.

Read responses go through a queue. The driver pushes the expected word when it issues the read, and a monitor pops and compares it on the falling edge where `rsp_valid` is high. A response with nothing queued, or a read still queued at the end, counts as a failure. Tick runs are counted exactly, so expected counts follow from the requirements alone.

// File: rtl/ttb_pkg.sv
// Package: shared register offsets for the tick timer bank.
// Assumes a 2-bit word offset inside each unit's register window.
package ttb_pkg;
    typedef enum logic [1:0] {
        OFS_LIMIT    = 2'd0,
        OFS_COUNT    = 2'd1,
        OFS_LIMIT_NC = 2'd2,
        OFS_AUX      = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/ttb_decode.sv
// Module: request decoder. Turns one register request into per-unit
// strobes for limit writes (clearing and non-clearing), limit reads and
// auxiliary writes. Assumes addresses with unit >= NUNIT are unused.
module ttb_decode
    import ttb_pkg::*;
#(
    parameter int NUNIT  = 5,
    parameter int UNIT_W = 3,
    parameter int ADDR_W = 5
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NUNIT-1:0]  wr_lim,
    output logic [NUNIT-1:0]  wr_nc,
    output logic [NUNIT-1:0]  rd_lim,
    output logic [NUNIT-1:0]  wr_aux
);
    logic [UNIT_W-1:0] unit;
    reg_ofs_e          ofs;

    assign unit = req_addr[ADDR_W-1:2];
    assign ofs  = reg_ofs_e'(req_addr[1:0]);

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        logic hit;
        // Unit selected by the current request.
        assign hit       = req_valid && (unit == UNIT_W'(u));
        assign wr_lim[u] = hit &&  req_write && (ofs == OFS_LIMIT);
        assign wr_nc[u]  = hit &&  req_write && (ofs == OFS_LIMIT_NC);
        assign rd_lim[u] = hit && !req_write && (ofs == OFS_LIMIT);
        assign wr_aux[u] = hit &&  req_write && (ofs == OFS_AUX);
    end
endmodule

// File: rtl/ttb_counter.sv
// Module: one limit timer. Counts ticks, wraps at a nonzero limit and
// sets a sticky flag; a limit read acknowledges the flag. In user mode it
// free-runs under a run gate with no flag. Assumes the strobes are
// single-cycle and mutually exclusive.
module ttb_counter #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             user_mode,
    input  logic             run,
    input  logic             wr_lim,
    input  logic             wr_nc,
    input  logic             rd_lim,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] limit_o,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] lim_q, cnt_q;
    logic             flag_q;
    logic             wrap;

    // A tick that lands on a nonzero limit in timer mode ends the period.
    assign wrap = tick && !user_mode && (lim_q != '0) && (cnt_q == lim_q) && !wr_lim;

    // Limit register: loaded by either limit address.
    always_ff @(posedge clk) begin
        if (!rst_n)              lim_q <= '0;
        else if (wr_lim || wr_nc) lim_q <= wdata;
    end

    // Count register: restart on clearing write, step or reload on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= ONE;
        else if (wr_lim)            cnt_q <= ONE;
        else if (user_mode) begin
            if (run && tick)        cnt_q <= cnt_q + ONE;
        end
        else if (wrap)              cnt_q <= ONE;
        else if (tick)              cnt_q <= cnt_q + ONE;
    end

    // Interrupt flag: set on wrap (wins over acknowledge), cleared by read or clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (user_mode)         flag_q <= 1'b0;
        else if (wrap)              flag_q <= 1'b1;
        else if (wr_lim || rd_lim)  flag_q <= 1'b0;
    end

    assign limit_o = lim_q;
    assign count_o = cnt_q;
    assign flag_o  = flag_q;

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim && !tick) |=> !flag_q);
    // R6
    nc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_nc && flag_q && !user_mode) |=> flag_q);
    // R7
    zero_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q == '0 && !wr_lim && !wr_nc && !flag_q) |=> !flag_q);
    // R10
    user_noirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |=> !flag_q);
    // R10
    user_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && run && tick && !wr_lim) |=> cnt_q == CNT_W'($past(cnt_q) + ONE));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lim) |=> $stable(cnt_q));
    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (cnt_q == ONE && $past(tick)));
endmodule

// File: rtl/ttb_rdmux.sv
// Module: registered read path. Selects the addressed register of the
// addressed unit and returns it one cycle later. Assumes run bits are
// supplied for every unit (system unit entry unused).
module ttb_rdmux
    import ttb_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int NUNIT  = 5,
    parameter int CNT_W  = 22,
    parameter int DW     = 32,
    parameter int UNIT_W = 3,
    parameter int ADDR_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [NUNIT-1:0][CNT_W-1:0] lim_all,
    input  logic [NUNIT-1:0][CNT_W-1:0] cnt_all,
    input  logic [NUNIT-1:0]            run_all,
    input  logic [NCPU-1:0]             cfg,
    output logic                        rsp_valid,
    output logic [DW-1:0]               rsp_data
);
    logic [UNIT_W-1:0] unit;
    reg_ofs_e          ofs;
    logic [DW-1:0]     sel;

    assign unit = req_addr[ADDR_W-1:2];
    assign ofs  = reg_ofs_e'(req_addr[1:0]);

    // Pick the addressed register; unused units return zero.
    always_comb begin
        sel = '0;
        if (unit < UNIT_W'(NUNIT)) begin
            case (ofs)
                OFS_LIMIT, OFS_LIMIT_NC: sel = DW'(lim_all[unit]);
                OFS_COUNT:               sel = DW'(cnt_all[unit]);
                default: begin
                    if (unit == UNIT_W'(NCPU)) sel = DW'(cfg);
                    else                       sel = DW'(run_all[unit]);
                end
            endcase
        end
    end

    // Response register: one cycle after an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rsp_data <= sel;
        end
    end

    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: rtl/tick_timer_bank.sv
// Module: top of the timer bank. One system timer (unit NCPU) and NCPU
// per-CPU timers sharing one tick enable and one register port. Holds
// the mode register and the per-CPU run bits. Assumes a single-cycle
// request with no back-pressure.
module tick_timer_bank
    import ttb_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CNT_W = 22,
    parameter int DW    = 32,
    localparam int NUNIT  = NCPU + 1,
    localparam int UNIT_W = $clog2(NUNIT),
    localparam int ADDR_W = UNIT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic              irq_sys,
    output logic [NCPU-1:0]   irq_cpu
);
    logic [NUNIT-1:0]            wr_lim, wr_nc, rd_lim, wr_aux;
    logic [NUNIT-1:0][CNT_W-1:0] lim_all, cnt_all;
    logic [NUNIT-1:0]            flag_all;
    logic [NUNIT-1:0]            run_all;
    logic [NCPU-1:0]             cfg_q;

    ttb_decode #(.NUNIT(NUNIT), .UNIT_W(UNIT_W), .ADDR_W(ADDR_W)) i_decode (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .wr_lim(wr_lim), .wr_nc(wr_nc), .rd_lim(rd_lim), .wr_aux(wr_aux)
    );

    // Mode register: bit i selects user-counter mode for CPU unit i.
    always_ff @(posedge clk) begin
        if (!rst_n)             cfg_q <= '0;
        else if (wr_aux[NCPU])  cfg_q <= req_wdata[NCPU-1:0];
    end

    assign run_all[NCPU] = 1'b0;

    for (genvar u = 0; u < NUNIT; u++) begin : g_tmr
        logic user_mode;
        if (u < NCPU) begin : g_cpu
            logic run_q;
            // Run bit of a per-CPU unit, written at offset 3.
            always_ff @(posedge clk) begin
                if (!rst_n)         run_q <= 1'b0;
                else if (wr_aux[u]) run_q <= req_wdata[0];
            end
            assign run_all[u] = run_q;
            assign user_mode  = cfg_q[u];
            assign irq_cpu[u] = flag_all[u];
        end else begin : g_sys
            assign user_mode = 1'b0;
            assign irq_sys   = flag_all[u];
        end

        ttb_counter #(.CNT_W(CNT_W)) i_counter (
            .clk(clk), .rst_n(rst_n), .tick(tick_en),
            .user_mode(user_mode), .run(run_all[u]),
            .wr_lim(wr_lim[u]), .wr_nc(wr_nc[u]), .rd_lim(rd_lim[u]),
            .wdata(req_wdata[CNT_W-1:0]),
            .limit_o(lim_all[u]), .count_o(cnt_all[u]), .flag_o(flag_all[u])
        );
    end

    ttb_rdmux #(.NCPU(NCPU), .NUNIT(NUNIT), .CNT_W(CNT_W), .DW(DW),
                .UNIT_W(UNIT_W), .ADDR_W(ADDR_W)) i_rdmux (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .lim_all(lim_all), .cnt_all(cnt_all),
        .run_all(run_all), .cfg(cfg_q), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // R9
    sys_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_sys) |-> $past(req_valid && req_addr[ADDR_W-1:2] == UNIT_W'(NCPU)
                                 && req_addr[1:0] == 2'd0));
    // R11
    rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;
    localparam int NCPU = 2;
    localparam int CNT_W = 8;
    localparam int DW = 32;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [DW-1:0] rsp_data;
    logic irq_sys;
    logic [NCPU-1:0] irq_cpu;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    tick_timer_bank #(.NCPU(NCPU), .CNT_W(CNT_W), .DW(DW)) i_tick_timer_bank (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_sys(irq_sys), .irq_cpu(irq_cpu)
    );

    function automatic int adr(input int unit, input int ofs);
        return unit * 4 + ofs;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one access, optionally with a tick in the same cycle.
    task automatic bus(input bit wr, input int a, input logic [DW-1:0] d,
                       input bit tk, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; tick_en = tk;
        if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        bus(1'b1, a, d, 1'b0, '0, "");
    endtask

    task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
        bus(1'b0, a, '0, 1'b0, exp, tag);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin @(negedge clk); tick_en = 1'b1; end
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic irq_chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        @(negedge clk);
        check(tag, act, exp);
    endtask

    // Monitor: compare each read response against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R11 unexpected response actual=%0h expected=none", rsp_data);
            end else begin
                check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        irq_chk("R1 irq_sys", DW'(irq_sys), 0);
        irq_chk("R1 irq_cpu", DW'(irq_cpu), 0);
        rd(adr(2, 0), 0, "R1 sys limit");
        rd(adr(2, 1), 1, "R1 sys count");
        rd(adr(2, 3), 0, "R1 mode reg");
        rd(adr(0, 3), 0, "R1 run bit");
        // R5 / R3 system timer period of 5
        wr(adr(2, 0), 5);
        ticks(4);
        irq_chk("R3 no irq before period", DW'(irq_sys), 0);
        rd(adr(2, 1), 5, "R3 count at limit");
        ticks(1);
        irq_chk("R3 R9 irq_sys set", DW'(irq_sys), 1);
        rd(adr(2, 1), 1, "R3 reload to 1");
        ticks(3);
        irq_chk("R4 flag sticky", DW'(irq_sys), 1);
        rd(adr(2, 2), 5, "R2 R8 noclear alias reads limit");
        irq_chk("R8 alias read no ack", DW'(irq_sys), 1);
        wr(adr(2, 1), 32'h77);
        rd(adr(2, 1), 4, "R8 count write ignored");
        rd(adr(2, 0), 5, "R4 limit read");
        irq_chk("R4 ack clears", DW'(irq_sys), 0);
        // R9 / R6 per-CPU unit 0
        wr(adr(0, 0), 3);
        ticks(3);
        irq_chk("R9 irq_cpu0 set", DW'(irq_cpu[0]), 1);
        irq_chk("R9 sys independent", DW'(irq_sys), 1);
        irq_chk("R9 cpu1 idle", DW'(irq_cpu[1]), 0);
        wr(adr(0, 2), 10);
        irq_chk("R6 noclear keeps flag", DW'(irq_cpu[0]), 1);
        rd(adr(0, 1), 1, "R6 noclear keeps count");
        rd(adr(0, 0), 10, "R6 new limit");
        irq_chk("R4 cpu0 ack", DW'(irq_cpu[0]), 0);
        // R4 collision of wrap and acknowledge
        wr(adr(1, 0), 2);
        ticks(1);
        bus(1'b0, adr(1, 0), '0, 1'b1, 2, "R4 collision read");
        irq_chk("R4 wrap wins over ack", DW'(irq_cpu[1]), 1);
        rd(adr(1, 0), 2, "R4 plain ack");
        irq_chk("R4 cleared after plain ack", DW'(irq_cpu[1]), 0);
        // R7 zero limit
        wr(adr(2, 0), 0);
        ticks(20);
        irq_chk("R7 no irq at limit 0", DW'(irq_sys), 0);
        rd(adr(2, 1), 21, "R7 count keeps rising");
        ticks(240);
        rd(adr(2, 1), 5, "R7 count wraps");
        // R10 user mode
        wr(adr(2, 3), 1);
        wr(adr(0, 0), 4);
        ticks(5);
        rd(adr(0, 1), 1, "R10 stopped counter holds");
        wr(adr(0, 3), 1);
        ticks(6);
        irq_chk("R10 no irq past limit", DW'(irq_cpu[0]), 0);
        rd(adr(0, 1), 7, "R10 running counter");
        ticks(250);
        rd(adr(0, 1), 1, "R10 wraps modulo");
        rd(adr(0, 3), 1, "R2 run bit readback");
        rd(adr(2, 3), 1, "R2 mode readback");
        wr(adr(2, 3), 0);
        ticks(3);
        irq_chk("R10 timer mode, not yet", DW'(irq_cpu[0]), 0);
        ticks(1);
        irq_chk("R10 timer mode wraps", DW'(irq_cpu[0]), 1);
        // R2 unused unit
        rd(adr(3, 0), 0, "R2 unused unit");
        repeat (4) @(negedge clk);
        check("R11 all responses seen", DW'(exp_q.size()), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule